// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Fault Capture

This block holds recently used page mappings for one side of a memory management unit, either the instruction side or the data side, with 8 KB pages. Each lookup takes a 32-bit virtual address, the current 8-bit process identifier, the access kind (read, write or execute), a user/supervisor flag and four protection-check enables. It searches the four ways of the set picked by the low page-number bits and returns, in the same cycle, either a physical address with granted permissions or a fault with an exception vector number.

Protection checks run in a fixed priority after a hit. Each check selects its own vector offset from a side-specific base. When a lookup that is not a debug probe misses or faults, two state registers are rewritten on the next clock edge. The first records the set index and way to use for a refill. The second records the faulting page, the access kind and the process identifier. On a plain miss the refill way comes from a 16-bit linear feedback shift register, which advances on every such event. Entries are loaded through a simple write port. Walking the page tables and dispatching the exception are left to the surrounding logic.

Top module: `tlb_lookup_unit`

## Requirements
- R1: A lookup uses virtual address bits [16:13] as the set index. It compares address bits [31:13] against the page number stored in each of the four ways of that set.
- R2: A way hits when its page number matches and either its global flag is set or its stored identifier equals `cur_pid`. When several ways hit, the lowest-numbered way is used.
- R3: On a granted access `xl_ok` is 1 and `xl_paddr` is the stored frame number in bits [31:13], followed by virtual address bits [12:0].
- R4: Checks after a hit, in priority order. `cfg_en` bit 3 enables the write check, bit 2 the supervisor check, bit 1 the execute check and bit 0 the valid check. `lk_kind` codes are 0 = read, 1 = write, 2 = execute; 3 acts as read.
  1. A user access to an entry with the supervisor-only flag set gives vector base+2.
  2. A write to an entry with the writable flag clear gives base+3.
  3. An execute of an entry with the executable flag clear gives base+3.
  4. An entry with the valid flag clear gives base+1.
  Flags are written as `wr_flags` = {global, valid, supervisor-only, writable, executable}, bit 4 down to bit 0.
- R5: A lookup that hits no way raises `xl_fault` with `xl_vec` equal to the base. The base is 4 on the instruction side (`INSN_SIDE`=1) and 8 on the data side. `xl_ok` and `xl_fault` are never both high, and both are low when `lk_valid` is low.
- R6: On a granted access:
  - read permission is always given;
  - write permission equals the entry's writable flag;
  - execute permission is given only on the instruction side, when `cfg_en` bit 1 or the executable flag is set.
  All three permissions are 0 on a fault, and `xl_vec` is 0 on a grant.
- R7: The refill-way register resets to 0xCCCC. Each step shifts it right by one and puts into bit 15 the parity of the register ANDed with 0x8805. It steps once per valid, non-debug lookup that faults.
- R8: After a valid, non-debug fault, `tlb_sel` holds the set index in bits [3:0] and a way in bits [5:4]. The way is the shift register's bits [1:0] before the step on a plain miss, and the hit way on a protection fault. It resets to 0.
- R9: After a valid, non-debug fault, `fault_cause` holds the page number in [31:13], zeros in [12:10], the access code in [9:8] and `cur_pid` in [7:0]. It resets to 0.
- R10: Granted lookups, debug lookups and cycles without a lookup leave `tlb_sel`, `fault_cause` and the shift register unchanged.
- R11: An entry written through the write port is seen by lookups from the next cycle on. A lookup in the same cycle sees the previous contents. Reset clears every entry to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one entry |
| wr_way | input | 2 | Way to load |
| wr_set | input | 4 | Set to load |
| wr_vpn | input | 19 | Virtual page number of the entry |
| wr_pid | input | 8 | Process identifier of the entry |
| wr_pfn | input | 19 | Physical frame number of the entry |
| wr_flags | input | 5 | {global, valid, supervisor-only, writable, executable} |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_user | input | 1 | User-mode access |
| lk_debug | input | 1 | Probe without state update |
| cur_pid | input | 8 | Current process identifier |
| cfg_en | input | 4 | Check enables {write, supervisor, execute, valid} |
| xl_ok | output | 1 | Access granted |
| xl_fault | output | 1 | Miss or protection fault |
| xl_vec | output | 4 | Exception vector number on a fault |
| xl_paddr | output | 32 | Physical address on a grant |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |
| tlb_sel | output | 6 | Refill way and set index |
| fault_cause | output | 32 | Captured fault information |

## Verification
Two functions can fall in the same cycle. One is an entry load through the write port. The other is a lookup of the address that the load targets. The bench drives both in one cycle: it expects a miss from the old contents, then a grant with the new frame number one cycle later. Two state changes can also meet on a single faulting lookup: a protection fault that also advances the shift register. This is judged by checking that `tlb_sel` reports the hit way rather than the register bits, while the next plain miss shows the stepped register value.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  localparam int PAGE_BITS = 13;
  localparam int VPN_W     = 32 - PAGE_BITS;
  localparam int PID_W     = 8;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  typedef struct packed {
    logic g;
    logic v;
    logic k;
    logic w;
    logic x;
  } flags_t;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] pfn;
    flags_t           fl;
  } entry_t;

endpackage

// File: rtl/tlbx_store.sv
module tlbx_store
  import tlbx_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(WAYS)-1:0]   wr_way,
  input  logic [$clog2(SETS)-1:0]   wr_set,
  input  entry_t                    wr_entry,
  input  logic [$clog2(SETS)-1:0]   rd_set,
  output entry_t [WAYS-1:0]         rd_row
);

  localparam int WAY_W = $clog2(WAYS);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    entry_t mem_q [SETS];
    logic   we;

    assign we = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) mem_q[s] <= '0;
      end else if (we) begin
        mem_q[wr_set] <= wr_entry;
      end
    end

    assign rd_row[w] = mem_q[rd_set];
  end

endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
  import tlbx_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  entry_t [WAYS-1:0]       row,
  input  logic [VPN_W-1:0]        vpn,
  input  logic [PID_W-1:0]        pid,
  output logic                    hit,
  output logic [$clog2(WAYS)-1:0] hit_way,
  output logic [VPN_W-1:0]        hit_pfn,
  output logic [3:0]              hit_vkwx
);

  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = (row[w].vpn == vpn) && (row[w].fl.g || (row[w].pid == pid));
  end

  // lowest way wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    hit_pfn  = '0;
    hit_vkwx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit      = 1'b1;
        hit_way  = WAY_W'(w);
        hit_pfn  = row[w].pfn;
        hit_vkwx = {row[w].fl.v, row[w].fl.k, row[w].fl.w, row[w].fl.x};
      end
    end
  end

endmodule

// File: rtl/tlbx_prot.sv
module tlbx_prot
  import tlbx_pkg::*;
#(
  parameter bit INSN_SIDE = 1'b0,
  parameter int VEC_W     = 4
) (
  input  logic             hit,
  input  logic [3:0]       vkwx,
  input  acc_e             kind,
  input  logic             user,
  input  logic [3:0]       cfg_en,
  output logic             ok,
  output logic             fault,
  output logic [VEC_W-1:0] vec,
  output logic             pr,
  output logic             pw,
  output logic             px
);

  localparam logic [VEC_W-1:0] BASE = INSN_SIDE ? VEC_W'(4) : VEC_W'(8);

  logic fl_v, fl_k, fl_w, fl_x;
  logic en_w, en_k, en_x, en_v;

  assign {fl_v, fl_k, fl_w, fl_x} = vkwx;
  assign {en_w, en_k, en_x, en_v} = cfg_en;

  always_comb begin
    ok    = 1'b0;
    fault = 1'b1;
    vec   = BASE;
    pr    = 1'b0;
    pw    = 1'b0;
    px    = 1'b0;
    if (hit) begin
      if (en_k && fl_k && user) begin
        vec = BASE + VEC_W'(2);
      end else if (kind == ACC_WRITE && en_w && !fl_w) begin
        vec = BASE + VEC_W'(3);
      end else if (kind == ACC_EXEC && en_x && !fl_x) begin
        vec = BASE + VEC_W'(3);
      end else if (en_v && !fl_v) begin
        vec = BASE + VEC_W'(1);
      end else begin
        ok    = 1'b1;
        fault = 1'b0;
        vec   = '0;
        pr    = 1'b1;
        pw    = fl_w;
        px    = INSN_SIDE && (en_x || fl_x);
      end
    end
  end

endmodule

// File: rtl/tlbx_fault_regs.sv
module tlbx_fault_regs
  import tlbx_pkg::*;
#(
  parameter int          LFSR_W = 16,
  parameter logic [15:0] TAPS   = 16'h8805,
  parameter logic [15:0] SEED   = 16'hCCCC,
  parameter int          IDX_W  = 4,
  parameter int          WAY_W  = 2,
  parameter int          CAUSE_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic                     miss,
  input  logic [WAY_W-1:0]         hit_way,
  input  logic [IDX_W-1:0]         idx,
  input  logic [VPN_W-1:0]         vpn,
  input  logic [PID_W-1:0]         pid,
  input  acc_e                     kind,
  output logic [LFSR_W-1:0]        lfsr_q,
  output logic [WAY_W+IDX_W-1:0]   sel_q,
  output logic [CAUSE_W-1:0]       cause_q
);

  localparam int PAD_W = CAUSE_W - VPN_W - 2 - PID_W;

  logic [LFSR_W-1:0]      lfsr_d;
  logic [WAY_W+IDX_W-1:0] sel_d;
  logic [CAUSE_W-1:0]     cause_d;
  logic [WAY_W-1:0]       way_pick;
  logic                   fb;

  assign fb       = ^(lfsr_q & TAPS[LFSR_W-1:0]);
  assign way_pick = miss ? lfsr_q[WAY_W-1:0] : hit_way;

  always_comb begin
    lfsr_d  = lfsr_q;
    sel_d   = sel_q;
    cause_d = cause_q;
    if (upd) begin
      lfsr_d  = {fb, lfsr_q[LFSR_W-1:1]};
      sel_d   = {way_pick, idx};
      cause_d = {vpn, {PAD_W{1'b0}}, kind, pid};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= SEED[LFSR_W-1:0];
      sel_q   <= '0;
      cause_q <= '0;
    end else if (upd) begin
      lfsr_q  <= lfsr_d;
      sel_q   <= sel_d;
      cause_q <= cause_d;
    end
  end

endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
  import tlbx_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int SETS      = 16,
  parameter bit INSN_SIDE = 1'b0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [$clog2(WAYS)-1:0]               wr_way,
  input  logic [$clog2(SETS)-1:0]               wr_set,
  input  logic [18:0]                           wr_vpn,
  input  logic [7:0]                            wr_pid,
  input  logic [18:0]                           wr_pfn,
  input  logic [4:0]                            wr_flags,
  input  logic                                  lk_valid,
  input  logic [31:0]                           lk_vaddr,
  input  logic [1:0]                            lk_kind,
  input  logic                                  lk_user,
  input  logic                                  lk_debug,
  input  logic [7:0]                            cur_pid,
  input  logic [3:0]                            cfg_en,
  output logic                                  xl_ok,
  output logic                                  xl_fault,
  output logic [3:0]                            xl_vec,
  output logic [31:0]                           xl_paddr,
  output logic                                  perm_r,
  output logic                                  perm_w,
  output logic                                  perm_x,
  output logic [$clog2(WAYS)+$clog2(SETS)-1:0]  tlb_sel,
  output logic [31:0]                           fault_cause
);

  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = $clog2(SETS);

  entry_t               wr_entry;
  entry_t [WAYS-1:0]    row;
  logic [VPN_W-1:0]     vpn;
  logic [IDX_W-1:0]     idx;
  acc_e                 kind;
  logic                 hit;
  logic [WAY_W-1:0]     hit_way;
  logic [VPN_W-1:0]     hit_pfn;
  logic [3:0]           hit_vkwx;
  logic                 ok_raw, fault_raw;
  logic [3:0]           vec_raw;
  logic                 pr_raw, pw_raw, px_raw;
  logic                 upd;
  logic [15:0]          lfsr_q;

  assign wr_entry = '{vpn: wr_vpn, pid: wr_pid, pfn: wr_pfn, fl: flags_t'(wr_flags)};
  assign vpn      = lk_vaddr[31:PAGE_BITS];
  assign idx      = vpn[IDX_W-1:0];
  assign kind     = (lk_kind == 2'd3) ? ACC_READ : acc_e'(lk_kind);

  tlbx_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_way   (wr_way),
    .wr_set   (wr_set),
    .wr_entry (wr_entry),
    .rd_set   (idx),
    .rd_row   (row)
  );

  tlbx_match #(.WAYS(WAYS)) u_match (
    .row      (row),
    .vpn      (vpn),
    .pid      (cur_pid),
    .hit      (hit),
    .hit_way  (hit_way),
    .hit_pfn  (hit_pfn),
    .hit_vkwx (hit_vkwx)
  );

  tlbx_prot #(.INSN_SIDE(INSN_SIDE), .VEC_W(4)) u_prot (
    .hit    (hit),
    .vkwx   (hit_vkwx),
    .kind   (kind),
    .user   (lk_user),
    .cfg_en (cfg_en),
    .ok     (ok_raw),
    .fault  (fault_raw),
    .vec    (vec_raw),
    .pr     (pr_raw),
    .pw     (pw_raw),
    .px     (px_raw)
  );

  assign upd = lk_valid && fault_raw && !lk_debug;

  tlbx_fault_regs #(
    .LFSR_W (16),
    .TAPS   (16'h8805),
    .SEED   (16'hCCCC),
    .IDX_W  (IDX_W),
    .WAY_W  (WAY_W),
    .CAUSE_W(32)
  ) u_fregs (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .miss    (!hit),
    .hit_way (hit_way),
    .idx     (idx),
    .vpn     (vpn),
    .pid     (cur_pid),
    .kind    (kind),
    .lfsr_q  (lfsr_q),
    .sel_q   (tlb_sel),
    .cause_q (fault_cause)
  );

  assign xl_ok    = lk_valid && ok_raw;
  assign xl_fault = lk_valid && fault_raw;
  assign xl_vec   = lk_valid ? vec_raw : '0;
  assign xl_paddr = xl_ok ? {hit_pfn, lk_vaddr[PAGE_BITS-1:0]} : '0;
  assign perm_r   = lk_valid && pr_raw;
  assign perm_w   = lk_valid && pw_raw;
  assign perm_x   = lk_valid && px_raw;

endmodule

// File: rtl/tlb_lookup_unit_chk.sv
module tlb_lookup_unit_chk #(
  parameter int WAYS      = 4,
  parameter int SETS      = 16,
  parameter bit INSN_SIDE = 1'b0
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 lk_valid,
  input logic [31:0]                          lk_vaddr,
  input logic                                 lk_debug,
  input logic [7:0]                           cur_pid,
  input logic                                 xl_ok,
  input logic                                 xl_fault,
  input logic [3:0]                           xl_vec,
  input logic [31:0]                          xl_paddr,
  input logic                                 perm_r,
  input logic                                 perm_w,
  input logic                                 perm_x,
  input logic [$clog2(WAYS)+$clog2(SETS)-1:0] tlb_sel,
  input logic [31:0]                          fault_cause,
  input logic [15:0]                          lfsr_q
);

  localparam int IDX_W = $clog2(SETS);
  localparam logic [3:0] BASE = INSN_SIDE ? 4'd4 : 4'd8;

  logic upd;
  assign upd = lk_valid && xl_fault && !lk_debug;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (xl_ok ^ xl_fault)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!xl_ok && !xl_fault)); // R5

  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> (xl_vec[3:2] == BASE[3:2])); // R4

  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> (!perm_r && !perm_w && !perm_x)); // R6

  AST_GRANT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    xl_ok |-> (perm_r && xl_vec == 4'd0)); // R6

  AST_DATA_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_ok && !INSN_SIDE) |-> !perm_x); // R6

  AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    xl_ok |-> (xl_paddr[12:0] == lk_vaddr[12:0])); // R3

  AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (lfsr_q[14:0] == $past(lfsr_q[15:1]))); // R7

  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(lfsr_q)); // R10

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(tlb_sel) && $stable(fault_cause))); // R10

  AST_SEL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (tlb_sel[IDX_W-1:0] == $past(lk_vaddr[13+IDX_W-1:13]))); // R8

  AST_CAUSE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (fault_cause[31:13] == $past(lk_vaddr[31:13]) &&
             fault_cause[7:0] == $past(cur_pid) &&
             fault_cause[12:10] == 3'd0 && fault_cause[9:8] != 2'd3)); // R9

endmodule

bind tlb_lookup_unit tlb_lookup_unit_chk #(
  .WAYS(WAYS), .SETS(SETS), .INSN_SIDE(INSN_SIDE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_vaddr    (lk_vaddr),
  .lk_debug    (lk_debug),
  .cur_pid     (cur_pid),
  .xl_ok       (xl_ok),
  .xl_fault    (xl_fault),
  .xl_vec      (xl_vec),
  .xl_paddr    (xl_paddr),
  .perm_r      (perm_r),
  .perm_w      (perm_w),
  .perm_x      (perm_x),
  .tlb_sel     (tlb_sel),
  .fault_cause (fault_cause),
  .lfsr_q      (lfsr_q)
);

// File: tb/tlb_lookup_unit_test.sv
module tlb_lookup_unit_test;

  typedef struct packed {
    logic [18:0] vpn;
    logic [12:0] off;
    logic [1:0]  kind;
    logic        user;
    logic [7:0]  pid;
    logic [3:0]  cfg;
    logic        ok;
    logic [3:0]  vec;
    logic [18:0] pfn;
    logic        w;
    logic [1:0]  way;
  } row_t;

  // rows exercise R1 R2 R3 R4 R5 R6; cfg = {W,K,X,V}
  localparam int NROWS = 13;
  localparam row_t TBL [NROWS] = '{
    '{19'h1,  13'h123,  2'd0, 1'b0, 8'd5, 4'hF, 1'b1, 4'd0,  19'h12345, 1'b1, 2'd0},
    '{19'h1,  13'h0,    2'd0, 1'b0, 8'd6, 4'hF, 1'b0, 4'd8,  19'h0,     1'b0, 2'd0},
    '{19'h11, 13'h4,    2'd0, 1'b1, 8'd6, 4'h4, 1'b0, 4'd10, 19'h0,     1'b0, 2'd2},
    '{19'h11, 13'h1FFF, 2'd0, 1'b0, 8'd6, 4'hF, 1'b1, 4'd0,  19'h0AAAA, 1'b0, 2'd2},
    '{19'h11, 13'h0,    2'd1, 1'b0, 8'd6, 4'h8, 1'b0, 4'd11, 19'h0,     1'b0, 2'd2},
    '{19'h11, 13'h0,    2'd1, 1'b1, 8'd6, 4'hC, 1'b0, 4'd10, 19'h0,     1'b0, 2'd2},
    '{19'h11, 13'h10,   2'd1, 1'b0, 8'd6, 4'h0, 1'b1, 4'd0,  19'h0AAAA, 1'b0, 2'd2},
    '{19'h11, 13'h0,    2'd2, 1'b0, 8'd6, 4'h2, 1'b0, 4'd11, 19'h0,     1'b0, 2'd2},
    '{19'h2,  13'h55,   2'd0, 1'b0, 8'd5, 4'h1, 1'b0, 4'd9,  19'h0,     1'b0, 2'd1},
    '{19'h2,  13'h55,   2'd0, 1'b0, 8'd5, 4'h0, 1'b1, 4'd0,  19'h777,   1'b1, 2'd1},
    '{19'h3,  13'h8,    2'd1, 1'b0, 8'd9, 4'h1, 1'b1, 4'd0,  19'h33,    1'b0, 2'd0},
    '{19'h21, 13'h0,    2'd0, 1'b0, 8'd5, 4'hF, 1'b0, 4'd8,  19'h0,     1'b0, 2'd0},
    '{19'h3,  13'h0,    2'd0, 1'b0, 8'd8, 4'h0, 1'b0, 4'd8,  19'h0,     1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_way;
  logic [3:0]  wr_set;
  logic [18:0] wr_vpn;
  logic [7:0]  wr_pid;
  logic [18:0] wr_pfn;
  logic [4:0]  wr_flags;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic        lk_user;
  logic        lk_debug;
  logic [7:0]  cur_pid;
  logic [3:0]  cfg_en;

  logic        xl_ok, xl_fault, perm_r, perm_w, perm_x;
  logic [3:0]  xl_vec;
  logic [31:0] xl_paddr, fault_cause;
  logic [5:0]  tlb_sel;
  logic        i_ok, i_fault, i_r, i_w, i_x;
  logic [3:0]  i_vec;
  logic [31:0] i_paddr, i_cause;
  logic [5:0]  i_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model;
  logic [5:0]  exp_sel;
  logic [31:0] exp_cause;

  always #10 clk = ~clk;

  tlb_lookup_unit #(.INSN_SIDE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set),
    .wr_vpn(wr_vpn), .wr_pid(wr_pid), .wr_pfn(wr_pfn), .wr_flags(wr_flags),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind), .lk_user(lk_user),
    .lk_debug(lk_debug), .cur_pid(cur_pid), .cfg_en(cfg_en),
    .xl_ok(xl_ok), .xl_fault(xl_fault), .xl_vec(xl_vec), .xl_paddr(xl_paddr),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
    .tlb_sel(tlb_sel), .fault_cause(fault_cause)
  );

  tlb_lookup_unit #(.INSN_SIDE(1'b1)) uut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set),
    .wr_vpn(wr_vpn), .wr_pid(wr_pid), .wr_pfn(wr_pfn), .wr_flags(wr_flags),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind), .lk_user(lk_user),
    .lk_debug(lk_debug), .cur_pid(cur_pid), .cfg_en(cfg_en),
    .xl_ok(i_ok), .xl_fault(i_fault), .xl_vec(i_vec), .xl_paddr(i_paddr),
    .perm_r(i_r), .perm_w(i_w), .perm_x(i_x),
    .tlb_sel(i_sel), .fault_cause(i_cause)
  );

  function automatic logic [15:0] step(input logic [15:0] s);
    return {^(s & 16'h8805), s[15:1]};
  endfunction

  task automatic check(input bit good, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] way, input logic [3:0] set, input logic [18:0] vpn,
                      input logic [7:0] pid, input logic [18:0] pfn, input logic [4:0] fl);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_set = set; wr_vpn = vpn; wr_pid = pid; wr_pfn = pfn; wr_flags = fl;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive at a falling edge, leave outputs settled for sampling
  task automatic look(input logic [18:0] vpn, input logic [12:0] off, input logic [1:0] kind,
                      input logic user, input logic [7:0] pid, input logic [3:0] cfg, input logic dbg);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_kind = kind; lk_user = user;
    cur_pid = pid; cfg_en = cfg; lk_debug = dbg;
    #5;
  endtask

  // let the rising edge pass, then drop the request
  task automatic settle();
    @(posedge clk);
    #3;
    lk_valid = 1'b0;
    #1;
  endtask

  // bench model of the state update, from R7 R8 R9
  task automatic expect_fault(input logic miss, input logic [1:0] way, input logic [18:0] vpn,
                              input logic [1:0] kind, input logic [7:0] pid);
    exp_sel   = {miss ? model[1:0] : way, vpn[3:0]};
    exp_cause = {vpn, 3'b000, kind, pid};
    model     = step(model);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_way = '0; wr_set = '0; wr_vpn = '0; wr_pid = '0;
    wr_pfn = '0; wr_flags = '0; lk_valid = 1'b0; lk_vaddr = '0; lk_kind = '0;
    lk_user = 1'b0; lk_debug = 1'b0; cur_pid = '0; cfg_en = '0;
    model = 16'hCCCC; exp_sel = '0; exp_cause = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(tlb_sel == 6'd0, "R8 reset tlb_sel", 32'(tlb_sel), 0);
    check(fault_cause == 32'd0, "R9 reset fault_cause", fault_cause, 0);
    check(!xl_ok && !xl_fault, "R5 idle outputs low", {xl_ok, xl_fault}, 0);

    look(19'h1, 13'h0, 2'd0, 1'b0, 8'd0, 4'h0, 1'b1);
    check(xl_fault && xl_vec == 4'd8, "R5 miss data base vector", 32'(xl_vec), 8);
    check(i_fault && i_vec == 4'd4, "R5 miss insn base vector", 32'(i_vec), 4);
    settle();
    check(tlb_sel == 6'd0, "R10 debug miss keeps tlb_sel", 32'(tlb_sel), 0);

    // cleared entry matches page 0 / pid 0 with valid clear
    look(19'h0, 13'h0, 2'd0, 1'b0, 8'd0, 4'h1, 1'b1);
    check(xl_fault && xl_vec == 4'd9, "R11 reset entry invalid", 32'(xl_vec), 9);
    settle();

    // entries, flags {G,V,K,W,X}
    load(2'd0, 4'd1, 19'h1,  8'd5, 19'h12345, 5'b01010);
    load(2'd2, 4'd1, 19'h11, 8'd7, 19'h0AAAA, 5'b11100);
    load(2'd1, 4'd2, 19'h2,  8'd5, 19'h777,   5'b00010);
    load(2'd3, 4'd2, 19'h2,  8'd5, 19'h999,   5'b01011);
    load(2'd0, 4'd3, 19'h3,  8'd9, 19'h33,    5'b01001);

    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      r = TBL[i];
      look(r.vpn, r.off, r.kind, r.user, r.pid, r.cfg, 1'b0);
      check(xl_ok == r.ok && xl_fault == !r.ok, $sformatf("R2 R5 row %0d outcome", i),
            {xl_ok, xl_fault}, {r.ok, !r.ok});
      check(xl_vec == r.vec, $sformatf("R4 row %0d vector", i), 32'(xl_vec), 32'(r.vec));
      if (r.ok) begin
        check(xl_paddr == {r.pfn, r.off}, $sformatf("R1 R3 row %0d paddr", i), xl_paddr, {r.pfn, r.off});
        check(perm_r && perm_w == r.w && !perm_x, $sformatf("R6 row %0d perms", i),
              {perm_r, perm_w, perm_x}, {1'b1, r.w, 1'b0});
      end else begin
        expect_fault(r.vec == 4'd8, r.way, r.vpn, r.kind, r.pid);
      end
      settle();
      check(tlb_sel == exp_sel, $sformatf("R8 row %0d tlb_sel", i), 32'(tlb_sel), 32'(exp_sel));
      check(fault_cause == exp_cause, $sformatf("R9 row %0d cause", i), fault_cause, exp_cause);
    end

    // debug probe leaves state alone, next real miss uses unstepped register
    look(19'h21, 13'h0, 2'd1, 1'b0, 8'd3, 4'h0, 1'b1);
    check(xl_fault, "R10 debug miss faults", 32'(xl_fault), 1);
    settle();
    check(tlb_sel == exp_sel && fault_cause == exp_cause, "R10 debug keeps state",
          fault_cause, exp_cause);
    look(19'h21, 13'h0, 2'd1, 1'b0, 8'd3, 4'h0, 1'b0);
    expect_fault(1'b1, 2'd0, 19'h21, 2'd1, 8'd3);
    settle();
    check(tlb_sel == exp_sel, "R7 way after debug probe", 32'(tlb_sel), 32'(exp_sel));

    // load and lookup of the same entry in one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_way = 2'd0; wr_set = 4'd4; wr_vpn = 19'h4; wr_pid = 8'd5;
    wr_pfn = 19'h44; wr_flags = 5'b01010;
    lk_valid = 1'b1; lk_vaddr = {19'h4, 13'h7}; lk_kind = 2'd0; lk_user = 1'b0;
    cur_pid = 8'd5; cfg_en = 4'h0; lk_debug = 1'b1;
    #5;
    check(xl_fault && xl_vec == 4'd8, "R11 same-cycle lookup sees old entry", 32'(xl_vec), 8);
    @(negedge clk);
    wr_en = 1'b0;
    #5;
    check(xl_ok && xl_paddr == {19'h44, 13'h7}, "R11 next-cycle lookup sees new entry",
          xl_paddr, {19'h44, 13'h7});
    settle();

    // instruction side: vector base and execute permission
    look(19'h3, 13'h0, 2'd2, 1'b0, 8'd9, 4'h0, 1'b1);
    check(i_ok && i_x, "R6 insn exec grant with X flag", {i_ok, i_x}, 2'b11);
    check(xl_ok && !perm_x, "R6 data side never grants exec", {xl_ok, perm_x}, 2'b10);
    settle();
    look(19'h3, 13'h0, 2'd0, 1'b0, 8'd9, 4'h2, 1'b1);
    check(i_ok && i_x, "R6 insn exec from config bit", {i_ok, i_x}, 2'b11);
    settle();
    look(19'h1, 13'h0, 2'd2, 1'b0, 8'd5, 4'h2, 1'b1);
    check(i_fault && i_vec == 4'd7, "R4 insn exec-protect vector", 32'(i_vec), 7);
    check(xl_fault && xl_vec == 4'd11, "R4 data exec-protect vector", 32'(xl_vec), 11);
    settle();

    // run of plain misses following the register sequence
    for (int n = 0; n < 24; n++) begin
      logic [18:0] v;
      v = 19'h100 + 19'(n);
      look(v, 13'h0, 2'd0, 1'b0, 8'd1, 4'h0, 1'b0);
      expect_fault(1'b1, 2'd0, v, 2'd0, 8'd1);
      settle();
      check(tlb_sel == exp_sel, $sformatf("R7 R8 miss run %0d", n), 32'(tlb_sel), 32'(exp_sel));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule